// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and presents one prioritized request to a processor. A source is a candidate for the processor when three conditions hold together. Its input line is high or software has forced it. Its 8-bit control byte is nonzero. Its mask bit is clear. Among the candidates, the one with the highest priority level wins, and on equal level the higher-numbered source wins. The block then drives a 3-bit level and an 8-bit vector to the processor. When no source is a candidate, the level is 0 and the vector is a fixed spurious value of 24.

Software reaches the block through a simple 32-bit register bus with an 8-bit byte offset. The bus exposes the following:
- the 64-bit pending, mask and force registers, each as two 32-bit words;
- one control byte per source;
- two mask commands that set or clear a single mask bit chosen by number;
- an acknowledge read that returns the vector currently presented.

Reads are combinational. A write takes effect at the clock edge on which it is presented.

The winner is recomputed every cycle from the register state and then registered. The processor-side outputs therefore lag the register state by one clock. They lag the input lines by two clocks, because the lines are first captured in the pending register.

Top module: `irqc_top`

## Requirements
- R1: After reset the vector output is 24 and the level output is 0. Every mask bit reads 1. Pending, force and all control bytes read 0.
- R2: The pending register captures the 64 input lines on every clock edge. Bus writes to offsets 0x00 and 0x04 leave it unchanged.
- R3: A source n is active when three conditions hold: (pending[n] or force[n]) is 1, control byte n is nonzero, and mask[n] is 0. Only active sources take part in selection.
- R4: The winner is the active source with the largest level field, where the level field is bits [2:0] of the source's control byte. On equal level fields, the higher source number wins.
- R5: With a winner n, the vector output is 64+n and the level output is that winner's level field. With no active source, the vector output is 24 and the level output is 0.
- R6: Control byte n is written from wdata[7:0] at offset 0x40+n. A read at that offset returns the byte in rdata[7:0], with upper bits 0. Writing zero disables source n.
- R7: The 64-bit registers are mapped as follows, with the high word (bits 63:32) first: pending at 0x00 and 0x04, mask at 0x08 and 0x0C, force at 0x10 and 0x14. Writing either half of the mask or force register leaves the other half unchanged.
- R8: A write to 0x1C sets mask bit wdata[5:0]. A write to 0x1D clears mask bit wdata[5:0]. No other mask bit changes.
- R9: A read at offset 0xE0 returns the presented vector in rdata[7:0]. A read at an unmapped offset returns 0.
- R10: The outputs reflect register state one clock after it changes, and input lines two clocks after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 64 | Level-sensitive interrupt lines, one per source |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| cpu_level | output | 3 | Priority level presented to the processor |
| cpu_vector | output | 8 | Vector presented to the processor |

## Verification
Several kinds of corrupted internal state are visible at the ports, as follows:
- A wrong pending, mask or force bit, or a wrong control byte, appears as a wrong winner. It shows on cpu_vector and cpu_level one clock after the state is reached, and it also shows directly on a register read.
- A tie or comparison error in the selector shows as a lower-numbered or lower-level source being presented.
- A broken mask command shows as an unexpected source number, or a spurious 24, after the next edge.

The sweeps cover three cases: each source alone, with its level checked; an all-equal tie; and pseudo-random mixes of lines, forces, masks and control bytes compared against an arithmetic model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NSRC    = 64;
    localparam int IDX_W   = $clog2(NSRC);
    localparam int CTRL_W  = 8;
    localparam int LVL_W   = 3;
    localparam int VEC_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int HALF_W  = NSRC / 2;

    localparam logic [VEC_W-1:0] SPUR_VEC = 8'd24;
    localparam logic [VEC_W-1:0] VEC_BASE = 8'd64;

    localparam logic [ADDR_W-1:0] OFF_PEND_HI = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PEND_LO = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MASK_HI = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_MASK_LO = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_FRC_HI  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_FRC_LO  = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_MSET    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_MCLR    = 8'h1D;
    localparam logic [ADDR_W-1:0] OFF_ACK     = 8'hE0;
    localparam logic [1:0]        CTRL_PAGE   = 2'b01;

    typedef struct packed {
        logic [NSRC-1:0]              pend;
        logic [NSRC-1:0]              mask;
        logic [NSRC-1:0]              frc;
        logic [NSRC-1:0][CTRL_W-1:0]  ctrl;
    } regs_t;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic [VEC_W-1:0] vector;
    } out_t;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     irq_lines,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output regs_t               regs_q
);
    regs_t regs_d;

    always_comb begin
        regs_d      = regs_q;
        regs_d.pend = irq_lines;
        if (bus_wr) begin
            if (bus_addr[ADDR_W-1 -: 2] == CTRL_PAGE) begin
                regs_d.ctrl[bus_addr[IDX_W-1:0]] = bus_wdata[CTRL_W-1:0];
            end else begin
                case (bus_addr)
                    OFF_MASK_HI: regs_d.mask[NSRC-1:HALF_W] = bus_wdata;
                    OFF_MASK_LO: regs_d.mask[HALF_W-1:0]    = bus_wdata;
                    OFF_FRC_HI:  regs_d.frc[NSRC-1:HALF_W]  = bus_wdata;
                    OFF_FRC_LO:  regs_d.frc[HALF_W-1:0]     = bus_wdata;
                    OFF_MSET:    regs_d.mask[bus_wdata[IDX_W-1:0]] = 1'b1;
                    OFF_MCLR:    regs_d.mask[bus_wdata[IDX_W-1:0]] = 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.pend <= '0;
            regs_q.mask <= '1;
            regs_q.frc  <= '0;
            regs_q.ctrl <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assert_pend_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> regs_q.pend == $past(irq_lines));

    assert_mask_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MSET) |=> regs_q.mask[$past(bus_wdata[IDX_W-1:0])] == 1'b1);

    assert_mask_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MCLR) |=> regs_q.mask[$past(bus_wdata[IDX_W-1:0])] == 1'b0);

    assert_frc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(regs_q.frc) && $stable(regs_q.mask) && $stable(regs_q.ctrl));
endmodule

// File: rtl/irqc_select.sv
module irqc_select
    import irqc_pkg::*;
(
    input  regs_t               regs,
    output logic                sel_valid,
    output logic [IDX_W-1:0]    sel_idx,
    output logic [LVL_W-1:0]    sel_level
);
    logic [NSRC-1:0] active;

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_act
            assign active[g] = (regs.pend[g] | regs.frc[g]) & ~regs.mask[g]
                             & (|regs.ctrl[g]);
        end
    endgenerate

    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = '0;
        sel_level = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (active[i] && regs.ctrl[i][LVL_W-1:0] >= sel_level) begin
                sel_valid = 1'b1;
                sel_idx   = IDX_W'(i);
                sel_level = regs.ctrl[i][LVL_W-1:0];
            end
        end
    end

    always_comb begin
        if (sel_valid) begin
            assert_winner_enabled_R3: assert (regs.ctrl[sel_idx] != '0 && !regs.mask[sel_idx]);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [63:0]         irq_lines,
    input  logic [7:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [2:0]          cpu_level,
    output logic [7:0]          cpu_vector
);
    regs_t            regs_q;
    logic             sel_valid;
    logic [IDX_W-1:0] sel_idx;
    logic [LVL_W-1:0] sel_level;
    out_t             out_d, out_q;

    irqc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .regs_q    (regs_q)
    );

    irqc_select u_sel (
        .regs      (regs_q),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx),
        .sel_level (sel_level)
    );

    always_comb begin
        out_d = out_q;
        if (sel_valid) begin
            out_d.level  = sel_level;
            out_d.vector = VEC_BASE + VEC_W'(sel_idx);
        end else begin
            out_d.level  = '0;
            out_d.vector = SPUR_VEC;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.level  <= '0;
            out_q.vector <= SPUR_VEC;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1 -: 2] == CTRL_PAGE) begin
            bus_rdata[CTRL_W-1:0] = regs_q.ctrl[bus_addr[IDX_W-1:0]];
        end else begin
            case (bus_addr)
                OFF_PEND_HI: bus_rdata = regs_q.pend[NSRC-1:HALF_W];
                OFF_PEND_LO: bus_rdata = regs_q.pend[HALF_W-1:0];
                OFF_MASK_HI: bus_rdata = regs_q.mask[NSRC-1:HALF_W];
                OFF_MASK_LO: bus_rdata = regs_q.mask[HALF_W-1:0];
                OFF_FRC_HI:  bus_rdata = regs_q.frc[NSRC-1:HALF_W];
                OFF_FRC_LO:  bus_rdata = regs_q.frc[HALF_W-1:0];
                OFF_ACK:     bus_rdata[VEC_W-1:0] = out_q.vector;
                default: ;
            endcase
        end
    end

    assign cpu_level  = out_q.level;
    assign cpu_vector = out_q.vector;

    assert_spur_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_vector == SPUR_VEC) |-> (cpu_level == '0));

    assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_vector == SPUR_VEC) || (cpu_vector >= VEC_BASE));

    assert_all_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (&regs_q.mask) |=> (cpu_vector == SPUR_VEC));

    assert_no_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl == '0) |=> (cpu_level == '0 && cpu_vector == SPUR_VEC));
endmodule

// File: tb/tb_irqc_top.sv
`timescale 1ns/1ps
module tb_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_lines = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  cpu_level;
    logic [7:0]  cpu_vector;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  ctrl_m [64];
    logic [63:0] mask_m, frc_m;
    logic [63:0] rnd = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_level(cpu_level), .cpu_vector(cpu_vector)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [10:0] model();
        logic [2:0] bl = 3'd0;
        logic [7:0] bv = 8'd24;
        for (int i = 0; i < 64; i++) begin
            if ((irq_lines[i] | frc_m[i]) && !mask_m[i] && ctrl_m[i] != 8'd0
                && ctrl_m[i][2:0] >= bl) begin
                bl = ctrl_m[i][2:0];
                bv = 8'(64 + i);
            end
        end
        return {bl, bv};
    endfunction

    task automatic chk_out(input string req);
        logic [10:0] e;
        logic [31:0] d;
        e = model();
        chk(req, {cpu_level, cpu_vector}, e);
        rd(8'hE0, d);
        chk({req, " R9 ack"}, d, {24'd0, e[7:0]});
    endtask

    function automatic logic [63:0] nxt(input logic [63:0] x);
        logic [63:0] y = x;
        y ^= y << 13; y ^= y >> 7; y ^= y << 17;
        return y;
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 64; i++) ctrl_m[i] = 8'd0;
        mask_m = '1; frc_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 level", cpu_level, 0);
        chk("R1 vector", cpu_vector, 24);
        rd(8'h08, d); chk("R1 mask hi", d, 32'hFFFF_FFFF);
        rd(8'h0C, d); chk("R1 mask lo", d, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R1 force hi", d, 0);
        rd(8'h14, d); chk("R1 force lo", d, 0);
        for (int i = 0; i < 64; i++) begin
            rd(8'(8'h40 + i), d); chk("R1 ctrl", d, 0);
        end

        // R2 pending capture, writes ignored
        irq_lines = 64'hDEAD_BEEF_0123_4567;
        settle();
        wr(8'h00, 32'h0); wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R2 pend hi", d, 32'hDEAD_BEEF);
        rd(8'h04, d); chk("R2 pend lo", d, 32'h0123_4567);
        rd(8'h20, d); chk("R9 unmapped", d, 0);
        chk_out("R3 all masked");

        // R6 control bytes
        for (int i = 0; i < 64; i++) begin
            ctrl_m[i] = 8'((i % 7) + 1) | 8'(i << 3);
            wr(8'(8'h40 + i), {24'hABCDEF, ctrl_m[i]});
        end
        for (int i = 0; i < 64; i++) begin
            rd(8'(8'h40 + i), d); chk("R6 readback", d, {24'd0, ctrl_m[i]});
        end

        // R5/R8 each source alone through set/clear by number
        for (int i = 0; i < 64; i++) begin
            irq_lines = 64'd1 << i;
            wr(8'h1D, 32'hFFFF_FF00 | 32'(i)); mask_m[i] = 1'b0;
            settle();
            chk("R5 single vector", cpu_vector, 64 + i);
            chk("R5 single level", cpu_level, (i % 7) + 1);
            wr(8'h1C, 32'(i) | 32'h40); mask_m[i] = 1'b1;
            rd(8'h08, d); chk("R8 mask hi", d, 32'hFFFF_FFFF);
            rd(8'h0C, d); chk("R8 mask lo", d, 32'hFFFF_FFFF);
        end

        // R7 half writes
        wr(8'h08, 32'h0); mask_m[63:32] = '0;
        rd(8'h0C, d); chk("R7 mask lo kept", d, 32'hFFFF_FFFF);
        wr(8'h0C, 32'h0); mask_m[31:0] = '0;
        rd(8'h08, d); chk("R7 mask hi", d, 0);

        // R4 tie: all same level, higher index wins
        for (int i = 0; i < 64; i++) begin ctrl_m[i] = 8'd3; wr(8'(8'h40 + i), 32'd3); end
        irq_lines = '1;
        settle();
        chk("R4 tie", cpu_vector, 127);
        chk_out("R4 tie model");

        // R6 zero disables
        ctrl_m[63] = 8'd0; wr(8'h7F, 32'd0);
        @(negedge clk);
        chk("R6 disabled", cpu_vector, 126);

        // R10 latency for register writes
        ctrl_m[5] = 8'd7;
        wr(8'h45, 32'd7);
        chk("R10 old value held", cpu_vector, 126);
        @(negedge clk);
        chk("R10 after one clock", cpu_vector, 69);
        // R10 latency for lines
        irq_lines = 64'd0;
        @(negedge clk);
        chk("R10 line one clock", cpu_vector, 69);
        @(negedge clk);
        chk("R10 line two clocks", cpu_vector, 24);

        // R3 force register, R7 force halves
        frc_m = 64'h0000_0100_0000_0000;
        wr(8'h10, 32'h0000_0100);
        rd(8'h14, d); chk("R7 force lo kept", d, 0);
        @(negedge clk);
        chk("R3 forced", cpu_vector, 64 + 40);
        frc_m = 64'h0000_0100_0000_0010;
        wr(8'h14, 32'h10);
        rd(8'h10, d); chk("R7 force hi kept", d, 32'h0000_0100);
        @(negedge clk);
        chk_out("R3 force mix");

        // Random mixes against the model
        for (int k = 0; k < 30; k++) begin
            for (int i = 0; i < 64; i++) begin
                rnd = nxt(rnd);
                ctrl_m[i] = (rnd[10:8] == 3'd0) ? 8'd0 : rnd[7:0];
                wr(8'(8'h40 + i), {24'd0, ctrl_m[i]});
            end
            rnd = nxt(rnd); mask_m = rnd | nxt(rnd);
            wr(8'h08, mask_m[63:32]); wr(8'h0C, mask_m[31:0]);
            rnd = nxt(rnd); frc_m = rnd & nxt(rnd) & nxt(nxt(rnd));
            wr(8'h10, frc_m[63:32]); wr(8'h14, frc_m[31:0]);
            rnd = nxt(rnd); irq_lines = rnd;
            settle();
            chk_out("R4 random");
        end

        summary();
    end
endmodule